// File: doc/BRIEF.md
# I2C Channel-Select Switch Controller

This block is the digital half of a bus switch that fans one upstream I2C bus out to eight downstream channels. It is an I2C target that oversamples SCL and SDA on a system clock, recognises START and STOP, matches its own 7-bit address and keeps an 8-bit selection register. Each bit of that register drives one channel-enable output, which in turn controls an external pass gate.

A write transaction delivers a selection byte, which is acknowledged and staged. The staged value reaches the enable outputs only when the next STOP is seen, so a channel is always connected while both bus lines are idle high. A read transaction returns the selection that is currently applied. Two active-low resets, one for power-on and one for recovery from a stuck bus, clear the register, the staged value and the protocol state.

Top module: `i2c_chansel_switch`

## Requirements
- R1: Bit n of the applied selection drives `chan_en[n]` (1 = connected, 0 = isolated), and any mix of the eight bits may be set together; writing 0x4C connects channels 2, 3 and 6, and 0xFF connects all eight.
- R2: After a data byte is acknowledged, `chan_en` keeps its previous value until a STOP condition is recognised on the bus.
- R3: While `rst_n` is low, `chan_en` is 0x00 and `sda_oe` is 0, and the block leaves reset idle with no channel connected.
- R4: Pulling `clr_n` low clears `chan_en` to 0x00 at once and discards any staged byte, so a later STOP in that transaction commits nothing.
- R5: A read transaction returns the applied selection as one byte, most significant bit first, with `sda_oe` high for each 0 bit; a master NACK ends the read.
- R6: START (SDA falls while SCL high) begins a transfer and STOP (SDA rises while SCL high) ends it; bits clocked without a preceding START are ignored and never acknowledged.
- R7: The target address is {4'b1110, `addr_sel`}, in the upper seven bits of the first byte with bit 0 the read flag (1 = read); a matching address is acknowledged (SDA low during the ninth clock) and any other address leaves the target silent until the next START or STOP, its data bytes ignored.
- R8: A repeated START keeps a staged byte pending: a read in the same transaction still returns the old selection and the staged byte is applied at the final STOP.
- R9: When a transaction writes several bytes the last acknowledged one is applied at STOP; a STOP with no completed data byte (none sent, or cut off mid-byte) leaves `chan_en` unchanged.
- R10: `sda_oe` is asserted only in acknowledge slots the target owns and for 0 bits of read data; it is never asserted while the master sends address or write data bits, and it is released after STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assertion |
| clr_n | input | 1 | Recovery reset pin, active low, same effect as power-on reset |
| addr_sel | input | 3 | Strap pins forming the low three address bits |
| scl_i | input | 1 | Upstream SCL line level |
| sda_i | input | 1 | Upstream SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| chan_en | output | 8 | Applied channel enables, one per downstream channel |

## Verification
On every cycle the assertions hold that the enables move only in the cycle after a recognised STOP and then take the staged byte, that a START always puts the target back to address reception, and that SDA is never driven while write data arrives, while an unaddressed transfer runs or after a STOP. Whether the address compare picks the right strap value, whether read data leaves in the correct bit order, and how repeated STARTs, multi-byte writes, truncated bytes and a mid-transaction clear combine can only be shown by the bench's bus scenarios, which compare the enable outputs against a behavioural model on every clock and check each acknowledge and read bit on the wire.

// File: rtl/i2csw_pkg.sv
package i2csw_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2csw_sync.sv
module i2csw_sync #(
  parameter int         W       = 2,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2csw_cond_det.sv
module i2csw_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  // SDA edges only count as conditions while SCL stays high across both samples.
  assign scl_rise  = !scl_d &&  scl_s;
  assign scl_fall  =  scl_d && !scl_s;
  assign start_det =  scl_d &&  scl_s &&  sda_d && !sda_s;
  assign stop_det  =  scl_d &&  scl_s && !sda_d &&  sda_s;
endmodule

// File: rtl/i2csw_target.sv
module i2csw_target
  import i2csw_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_rise,
  input  logic                   scl_fall,
  input  logic                   start_det,
  input  logic                   stop_det,
  input  logic                   sda_s,
  input  logic [ADDR_W-1:0]      dev_addr,
  input  logic [BYTE_W-1:0]      status,
  output logic                   wr_strobe,
  output logic [BYTE_W-1:0]      wr_data,
  output logic                   sda_oe,
  output tgt_state_e             state_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              full_q, full_d;
  logic              rd_q, rd_d;
  logic              nack_q, nack_d;
  logic              strobe;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    full_d  = full_q;
    rd_d    = rd_q;
    nack_d  = nack_q;
    strobe  = 1'b0;

    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      full_d  = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      full_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            rx_d  = {rx_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) full_d = 1'b1;
          end else if (scl_fall && full_q) begin
            full_d = 1'b0;
            if (state_q == ST_ADDR) begin
              rd_d    = rx_q[0];
              state_d = (rx_q[BYTE_W-1:1] == dev_addr) ? ST_AACK : ST_SKIP;
            end else begin
              strobe  = 1'b1;
              state_d = ST_WACK;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rd_q) begin
              tx_d    = status;
              state_d = ST_RDAT;
            end else begin
              state_d = ST_WDAT;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            cnt_d   = '0;
            state_d = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) state_d = ST_RACK;
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (nack_q) begin
              state_d = ST_SKIP;
            end else begin
              tx_d    = status;
              state_d = ST_RDAT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      full_q  <= 1'b0;
      rd_q    <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      full_q  <= full_d;
      rd_q    <= rd_d;
      nack_q  <= nack_d;
    end
  end

  assign wr_strobe = strobe;
  assign wr_data   = rx_q;
  assign sda_oe    = (state_q == ST_AACK) || (state_q == ST_WACK) ||
                     ((state_q == ST_RDAT) && !tx_q[BYTE_W-1]);
  assign state_o   = state_q;
endmodule

// File: rtl/i2csw_chan_reg.sv
module i2csw_chan_reg #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_strobe,
  input  logic [NCH-1:0] wr_data,
  input  logic           stop_det,
  output logic [NCH-1:0] chan_en,
  output logic           pend_valid,
  output logic [NCH-1:0] pend_data
);
  logic [NCH-1:0] en_q, en_d, pend_q, pend_d;
  logic           pv_q, pv_d;
  logic           en_ld;

  always_comb begin
    pend_d = pend_q;
    pv_d   = pv_q;
    en_ld  = 1'b0;
    en_d   = en_q;
    if (stop_det) begin
      en_ld = pv_q;
      en_d  = pend_q;
      pv_d  = 1'b0;
    end else if (wr_strobe) begin
      pend_d = wr_data;
      pv_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      pv_q   <= 1'b0;
    end else begin
      if (en_ld) en_q <= en_d;
      pend_q <= pend_d;
      pv_q   <= pv_d;
    end
  end

  assign chan_en    = en_q;
  assign pend_valid = pv_q;
  assign pend_data  = pend_q;
endmodule

// File: rtl/i2c_chansel_switch.sv
module i2c_chansel_switch
  import i2csw_pkg::*;
#(
  parameter int               NCH         = BYTE_W,
  parameter logic [3:0]       ADDR_PREFIX = 4'b1110,
  parameter int               SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_n,
  input  logic [2:0]     addr_sel,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_oe,
  output logic [NCH-1:0] chan_en
);
  localparam logic [ADDR_W-1:0] DEV_BASE = {ADDR_PREFIX, 3'b000};

  logic       arst_n;
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  // Either reset asserts at once; release is aligned to the clock.
  assign arst_n = rst_n & clr_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [1:0] bus_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic       wr_strobe;
  logic [BYTE_W-1:0] wr_data;
  logic       pend_valid;
  logic [NCH-1:0] pend_data;
  tgt_state_e tgt_state;

  i2csw_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({scl_i, sda_i}),
    .q     (bus_s)
  );

  i2csw_cond_det u_cond (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_s     (bus_s[1]),
    .sda_s     (bus_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2csw_target u_tgt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (bus_s[0]),
    .dev_addr  (DEV_BASE | ADDR_W'(addr_sel)),
    .status    (chan_en),
    .wr_strobe (wr_strobe),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe),
    .state_o   (tgt_state)
  );

  i2csw_chan_reg #(.NCH(NCH)) u_reg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_strobe  (wr_strobe),
    .wr_data    (wr_data),
    .stop_det   (stop_det),
    .chan_en    (chan_en),
    .pend_valid (pend_valid),
    .pend_data  (pend_data)
  );
endmodule

// File: rtl/i2csw_checker.sv
module i2csw_checker
  import i2csw_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_det,
  input logic           stop_det,
  input logic           pend_valid,
  input logic [NCH-1:0] pend_data,
  input logic [NCH-1:0] chan_en,
  input logic           sda_oe,
  input tgt_state_e     tgt_state
);
  // R2: enables hold unless a STOP was recognised in the previous cycle
  p_hold_until_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_det |=> $stable(chan_en));

  // R1: a STOP with a staged byte applies exactly that byte
  p_commit_on_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && pend_valid) |=> (chan_en == $past(pend_data)));

  // R6: START always restarts address reception
  p_start_to_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (tgt_state == ST_ADDR));

  // R10: no drive while the master sends write data
  p_no_drive_wdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_state == ST_WDAT) |-> !sda_oe);

  // R7: an unaddressed target stays silent
  p_silent_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_state == ST_SKIP) |-> !sda_oe);

  // R10: SDA is released after STOP
  p_release_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

bind i2c_chansel_switch i2csw_checker #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .pend_valid (pend_valid),
  .pend_data  (pend_data),
  .chan_en    (chan_en),
  .sda_oe     (sda_oe),
  .tgt_state  (tgt_state)
);

// File: tb/i2c_chansel_switch_tb.sv
module i2c_chansel_switch_tb;
  localparam int Q = 6;            // clocks per quarter bit
  localparam logic [6:0] MY_ADDR = 7'h75;

  logic clk = 1'b0;
  logic rst_n, clr_n;
  logic [2:0] addr_sel;
  logic scl_m, sda_m;
  logic sda_oe;
  logic [7:0] chan_en;
  logic sda_line;

  int checks = 0;
  int errors = 0;

  // behavioural reference
  logic [7:0] ref_en, ref_old, ref_pend;
  bit   ref_pv, ref_wsel;
  int   settle = 0;
  bit   mon_on = 0;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_chansel_switch u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .addr_sel (addr_sel),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .chan_en  (chan_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, sampled a quarter period after the edge
  always begin
    @(posedge clk);
    #5;
    if (mon_on) begin
      if (settle > 0) begin
        chk(chan_en == ref_old || chan_en == ref_en, "R2 settle", chan_en, ref_en);
        settle--;
      end else begin
        chk(chan_en == ref_en, "R1/R2 per-clock", chan_en, ref_en);
      end
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1;
    ref_old = ref_en;
    if (ref_pv) ref_en = ref_pend;
    ref_pv = 0; ref_wsel = 0; settle = 6;
    wq(); wq();
  endtask

  task automatic send_bit(input logic b, input bit check_drive);
    sda_m = b; wq(); scl_m = 1'b1; wq();
    if (check_drive) chk(sda_oe == 1'b0, "R10 no drive on master bit", sda_oe, 0);
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, input bit exp_ack, input string req);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i], 1'b1);
    recv_bit(a);
    chk(a == !exp_ack, req, a, !exp_ack);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic master_ack, input string req);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    chk(v == exp, req, v, exp);
    send_bit(master_ack, 1'b0);
  endtask

  task automatic write_sel(input logic [7:0] v);
    send_byte(v, 1'b1, "R7 data ack");
    if (ref_wsel) begin ref_pend = v; ref_pv = 1; end
  endtask

  task automatic addr_phase(input logic [6:0] a, input logic rd);
    bit match = (a == MY_ADDR);
    send_byte({a, rd}, match, "R7 address ack");
    ref_wsel = match && !rd;
  endtask

  task automatic wait_idle(); repeat (12) @(negedge clk); endtask

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; addr_sel = 3'b101;
    scl_m = 1'b1; sda_m = 1'b1;
    ref_en = '0; ref_old = '0; ref_pend = '0; ref_pv = 0; ref_wsel = 0;
    repeat (5) @(negedge clk);
    chk(chan_en == 8'h00, "R3 reset enables", chan_en, 0);
    chk(sda_oe == 1'b0, "R3 reset sda_oe", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_on = 1;

    // R1, R2: staged write applied only at STOP
    bus_start(); addr_phase(MY_ADDR, 0); write_sel(8'h4C);
    chk(chan_en == 8'h00, "R2 held before STOP", chan_en, 0);
    bus_stop(); wait_idle();
    chk(chan_en == 8'h4C, "R1 channels 2,3,6", chan_en, 8'h4C);

    // R5: read returns applied selection
    bus_start(); addr_phase(MY_ADDR, 1);
    recv_byte(8'h4C, 1'b0, "R5 read status");
    recv_byte(8'h4C, 1'b1, "R5 second read byte");
    bus_stop(); wait_idle();
    chk(chan_en == 8'h4C, "R5 read leaves enables", chan_en, 8'h4C);

    // R7: mismatched address ignored
    bus_start(); addr_phase(7'h74, 0);
    send_byte(8'hFF, 1'b0, "R7 no ack for foreign data");
    bus_stop(); wait_idle();
    chk(chan_en == 8'h4C, "R7 foreign write ignored", chan_en, 8'h4C);

    // R9: several bytes, last one wins
    bus_start(); addr_phase(MY_ADDR, 0);
    write_sel(8'h11); write_sel(8'h22); write_sel(8'h5A);
    bus_stop(); wait_idle();
    chk(chan_en == 8'h5A, "R9 last byte committed", chan_en, 8'h5A);

    // R9: STOP with no data byte, then STOP mid-byte
    bus_start(); addr_phase(MY_ADDR, 0);
    bus_stop(); wait_idle();
    chk(chan_en == 8'h5A, "R9 address-only write", chan_en, 8'h5A);
    bus_start(); addr_phase(MY_ADDR, 0);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b1);
    bus_stop(); wait_idle();
    chk(chan_en == 8'h5A, "R9 truncated byte", chan_en, 8'h5A);

    // R8: repeated START keeps the staged byte pending
    bus_start(); addr_phase(MY_ADDR, 0); write_sel(8'h81);
    bus_start(); addr_phase(MY_ADDR, 1);
    recv_byte(8'h5A, 1'b1, "R8 read sees old selection");
    chk(chan_en == 8'h5A, "R8 pending not applied", chan_en, 8'h5A);
    bus_stop(); wait_idle();
    chk(chan_en == 8'h81, "R8 committed at final STOP", chan_en, 8'h81);

    // R6: bits clocked without START are ignored
    scl_m = 1'b0; wq();
    ref_wsel = 0;
    send_byte({MY_ADDR, 1'b0}, 1'b0, "R6 no ack without START");
    send_byte(8'h00, 1'b0, "R6 no ack data without START");
    bus_stop(); wait_idle();
    chk(chan_en == 8'h81, "R6 stray bits ignored", chan_en, 8'h81);

    // R1: all channels at once
    bus_start(); addr_phase(MY_ADDR, 0); write_sel(8'hFF);
    bus_stop(); wait_idle();
    chk(chan_en == 8'hFF, "R1 all channels", chan_en, 8'hFF);

    // R4: recovery clear mid-transaction drops the staged byte
    bus_start(); addr_phase(MY_ADDR, 0); write_sel(8'h3C);
    clr_n = 1'b0; ref_en = 8'h00; ref_old = 8'h00; ref_pv = 0; ref_wsel = 0;
    repeat (4) @(negedge clk);
    chk(chan_en == 8'h00, "R4 clear deselects", chan_en, 0);
    chk(sda_oe == 1'b0, "R4 clear releases SDA", sda_oe, 0);
    clr_n = 1'b1; repeat (4) @(negedge clk);
    bus_stop(); wait_idle();
    chk(chan_en == 8'h00, "R4 staged byte discarded", chan_en, 0);

    // R4: block usable again after clear
    bus_start(); addr_phase(MY_ADDR, 0); write_sel(8'h0F);
    bus_stop(); wait_idle();
    chk(chan_en == 8'h0F, "R4 write after clear", chan_en, 8'h0F);
    bus_start(); addr_phase(MY_ADDR, 1);
    recv_byte(8'h0F, 1'b1, "R5 read after clear");
    bus_stop(); wait_idle();

    mon_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule